// File: doc/BRIEF.md
# Threshold-Qualified Event Counter

This block is a 64-bit performance counter whose increments are filtered by a threshold test. On every clock, the event source reports how many occurrences of one monitored event happened in that cycle. A small set of configuration registers holds a threshold, a two-bit comparison selector and a "count qualifying cycles" bit. On a cycle whose event count passes the comparison, the counter grows either by that cycle's count or by exactly one. A cycle that fails the comparison leaves the counter alone.

Each instance has a fixed largest supported threshold, which it reports as a capability value. A requested threshold above that limit is stored as the limit, with no error. An instance built without threshold support reports a capability of zero, ignores the filter settings, and counts every event. Software can load or read the counter at any time. A global enable stops all counting. A sticky flag records each wrap of the counter past its top value.

Top module: `thr_event_counter`

## Requirements
- R1: After a synchronous reset, the counter, the overflow flag, the stored threshold, the comparison selector and the count-cycles bit all read zero.
- R2: The comparison selector picks how the cycle's event count (zero-extended to 12 bits) is tested against the stored threshold: code 0 passes when they differ, code 1 when they are equal, code 2 when the count is greater than or equal to the threshold, and code 3 when the count is less than it.
- R3: With the count-cycles bit clear, a passing cycle adds its full event count to the counter, and a failing cycle leaves the counter unchanged.
- R4: With the count-cycles bit set, a passing cycle adds exactly one, even when its event count is zero.
- R5: The capability output reports the largest supported threshold (255 by default). A threshold write above that value stores the value itself, and a write at or below it stores the written value.
- R6: When the block is built without threshold support, the capability output, the stored threshold, the selector and the count-cycles bit all read zero, and every cycle adds its raw event count whatever was written to the configuration.
- R7: While the enable input is low, the counter does not increment.
- R8: A software counter write loads the written value on the next edge and takes priority over any increment in the same cycle. The counter value is always visible on the counter output.
- R9: An increment that carries past the top of the 64-bit range wraps the counter modulo 2^64 and sets the sticky overflow flag. Writing 1 to the overflow-clear input clears the flag. If a wrap and a clear happen in the same cycle, the flag stays set.
- R10: A configuration write takes effect from the next cycle. An event presented in the same cycle as the write is judged under the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Global count enable |
| evt_cnt_i | input | 4 | Number of events seen this cycle |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_thr_i | input | 12 | Requested threshold |
| cfg_mode_i | input | 2 | Comparison selector (0 ne, 1 eq, 2 ge, 3 lt) |
| cfg_cnt1_i | input | 1 | Count qualifying cycles instead of events |
| cnt_wr_i | input | 1 | Software counter load strobe |
| cnt_wdata_i | input | 64 | Value to load into the counter |
| ovf_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| cnt_o | output | 64 | Current counter value |
| ovf_o | output | 1 | Sticky overflow flag |
| cap_thr_o | output | 12 | Largest supported threshold (0 when the feature is absent) |
| thr_o | output | 12 | Stored (clamped) threshold |
| mode_o | output | 2 | Stored comparison selector |
| cnt1_o | output | 1 | Stored count-cycles bit |

## Verification
The bench sweeps every event count from 0 to 15 under each comparison code with threshold 5. A swapped or off-by-one comparison would show up as a wrong total. It checks that a zero-event cycle adds one in count-cycles mode, so a design that adds one only for nonzero counts fails. It also writes thresholds of 4095, 300 and 255 against a limit of 255, which catches a design that truncates instead of clamping.

The bench drives the counter near 2^64 to test wrap-around and the sticky flag, including a clear in the same cycle as a wrap, where a design that lets the clear win would drop the flag. It issues a configuration write together with an event to catch a design that applies new settings one cycle early. A second instance built without threshold support must count raw events regardless of its configuration.

// File: rtl/thr_cnt_pkg.sv
package thr_cnt_pkg;
  typedef enum logic [1:0] {
    CMP_NE = 2'd0,
    CMP_EQ = 2'd1,
    CMP_GE = 2'd2,
    CMP_LT = 2'd3
  } cmp_mode_e;
endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
  import thr_cnt_pkg::*;
#(
  parameter int THR_W   = 12,
  parameter int THR_MAX = 255,
  parameter bit HAS_THR = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [THR_W-1:0] thr_i,
  input  cmp_mode_e        mode_i,
  input  logic             cnt1_i,
  output logic [THR_W-1:0] thr_q,
  output cmp_mode_e        mode_q,
  output logic             cnt1_q
);
  localparam logic [THR_W-1:0] THR_CAP = THR_MAX[THR_W-1:0];

  generate
    if (HAS_THR) begin : g_regs
      logic [THR_W-1:0] thr_clamped;
      assign thr_clamped = (thr_i > THR_CAP) ? THR_CAP : thr_i;

      always_ff @(posedge clk) begin
        if (rst) begin
          thr_q  <= '0;
          mode_q <= CMP_NE;
          cnt1_q <= 1'b0;
        end else if (wr_i) begin
          thr_q  <= thr_clamped;
          mode_q <= mode_i;
          cnt1_q <= cnt1_i;
        end
      end
    end else begin : g_none
      assign thr_q  = '0;
      assign mode_q = CMP_NE;
      assign cnt1_q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/thr_qualifier.sv
module thr_qualifier
  import thr_cnt_pkg::*;
#(
  parameter int EVT_W   = 4,
  parameter int THR_W   = 12,
  parameter int CNT_W   = 64,
  parameter bit HAS_THR = 1'b1
) (
  input  logic [EVT_W-1:0] evt_i,
  input  logic [THR_W-1:0] thr_i,
  input  cmp_mode_e        mode_i,
  input  logic             cnt1_i,
  output logic             pass_o,
  output logic [CNT_W-1:0] inc_o
);
  logic [THR_W-1:0] evt_ext;
  logic             cmp_hit;

  assign evt_ext = {{(THR_W-EVT_W){1'b0}}, evt_i};

  always_comb begin
    unique case (mode_i)
      CMP_NE:  cmp_hit = (evt_ext != thr_i);
      CMP_EQ:  cmp_hit = (evt_ext == thr_i);
      CMP_GE:  cmp_hit = (evt_ext >= thr_i);
      default: cmp_hit = (evt_ext <  thr_i);
    endcase
  end

  generate
    if (HAS_THR) begin : g_filter
      assign pass_o = cmp_hit;
      assign inc_o  = cnt1_i ? {{(CNT_W-1){1'b0}}, 1'b1}
                             : {{(CNT_W-EVT_W){1'b0}}, evt_i};
    end else begin : g_raw
      assign pass_o = 1'b1;
      assign inc_o  = {{(CNT_W-EVT_W){1'b0}}, evt_i};
    end
  endgenerate
endmodule

// File: rtl/thr_accum.sv
module thr_accum #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_i,
  input  logic [CNT_W-1:0] inc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  logic [CNT_W:0] sum;
  logic           wrap;

  assign sum  = {1'b0, cnt_q} + {1'b0, inc_i};
  assign wrap = add_i && !wr_i && sum[CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_i) begin
      cnt_q <= wdata_i;
    end else if (add_i) begin
      cnt_q <= sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
    end else if (wrap) begin
      ovf_q <= 1'b1;
    end else if (ovf_clr_i) begin
      ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/thr_event_counter.sv
module thr_event_counter
  import thr_cnt_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int EVT_W   = 4,
  parameter int THR_W   = 12,
  parameter int THR_MAX = 255,
  parameter bit HAS_THR = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [EVT_W-1:0] evt_cnt_i,
  input  logic             cfg_wr_i,
  input  logic [THR_W-1:0] cfg_thr_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic             cfg_cnt1_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic [THR_W-1:0] cap_thr_o,
  output logic [THR_W-1:0] thr_o,
  output logic [1:0]       mode_o,
  output logic             cnt1_o
);
  localparam logic [THR_W-1:0] CAP_VAL = HAS_THR ? THR_MAX[THR_W-1:0] : '0;

  logic [THR_W-1:0] thr_q;
  cmp_mode_e        mode_q;
  logic             cnt1_q;
  logic             pass;
  logic [CNT_W-1:0] inc;

  thr_cfg_regs #(
    .THR_W(THR_W), .THR_MAX(THR_MAX), .HAS_THR(HAS_THR)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_i(cfg_wr_i), .thr_i(cfg_thr_i),
    .mode_i(cmp_mode_e'(cfg_mode_i)), .cnt1_i(cfg_cnt1_i),
    .thr_q(thr_q), .mode_q(mode_q), .cnt1_q(cnt1_q)
  );

  thr_qualifier #(
    .EVT_W(EVT_W), .THR_W(THR_W), .CNT_W(CNT_W), .HAS_THR(HAS_THR)
  ) u_qual (
    .evt_i(evt_cnt_i), .thr_i(thr_q), .mode_i(mode_q), .cnt1_i(cnt1_q),
    .pass_o(pass), .inc_o(inc)
  );

  thr_accum #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .add_i(en_i && pass), .inc_i(inc),
    .wr_i(cnt_wr_i), .wdata_i(cnt_wdata_i), .ovf_clr_i(ovf_clr_i),
    .cnt_q(cnt_o), .ovf_q(ovf_o)
  );

  assign cap_thr_o = CAP_VAL;
  assign thr_o     = thr_q;
  assign mode_o    = mode_q;
  assign cnt1_o    = cnt1_q;
endmodule

// File: rtl/thr_event_counter_chk.sv
module thr_event_counter_chk #(
  parameter int CNT_W = 64,
  parameter int THR_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             cnt_wr_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic             ovf_clr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             ovf_o,
  input logic [THR_W-1:0] cap_thr_o,
  input logic [THR_W-1:0] thr_o,
  input logic             cnt1_o
);
  // R7
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !cnt_wr_i) |=> $stable(cnt_o));

  // R8
  sw_write_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_i |=> (cnt_o == $past(cnt_wdata_i)));

  // R5
  thr_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    thr_o <= cap_thr_o);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_o) |-> $past(ovf_clr_i));

  // R4
  one_per_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && !cnt_wr_i && cnt1_o) |=> ((cnt_o - $past(cnt_o)) <= CNT_W'(1)));

  // R3
  raw_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && !cnt_wr_i) |=> ((cnt_o - $past(cnt_o)) <= CNT_W'(15)));
endmodule

bind thr_event_counter thr_event_counter_chk #(.CNT_W(CNT_W), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .cnt_wr_i(cnt_wr_i),
  .cnt_wdata_i(cnt_wdata_i), .ovf_clr_i(ovf_clr_i), .cnt_o(cnt_o),
  .ovf_o(ovf_o), .cap_thr_o(cap_thr_o), .thr_o(thr_o), .cnt1_o(cnt1_o)
);

// File: tb/thr_event_counter_tb_top.sv
module thr_event_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        en_i;
  logic [3:0]  evt_cnt_i;
  logic        cfg_wr_i;
  logic [11:0] cfg_thr_i;
  logic [1:0]  cfg_mode_i;
  logic        cfg_cnt1_i;
  logic        cnt_wr_i;
  logic [63:0] cnt_wdata_i;
  logic        ovf_clr_i;
  logic [63:0] cnt_o, n_cnt_o;
  logic        ovf_o, n_ovf_o;
  logic [11:0] cap_thr_o, thr_o, n_cap_thr_o, n_thr_o;
  logic [1:0]  mode_o, n_mode_o;
  logic        cnt1_o, n_cnt1_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thr_event_counter dut_i (
    .clk(clk), .rst(rst), .en_i(en_i), .evt_cnt_i(evt_cnt_i),
    .cfg_wr_i(cfg_wr_i), .cfg_thr_i(cfg_thr_i), .cfg_mode_i(cfg_mode_i),
    .cfg_cnt1_i(cfg_cnt1_i), .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
    .ovf_clr_i(ovf_clr_i), .cnt_o(cnt_o), .ovf_o(ovf_o),
    .cap_thr_o(cap_thr_o), .thr_o(thr_o), .mode_o(mode_o), .cnt1_o(cnt1_o)
  );

  thr_event_counter #(.HAS_THR(1'b0)) nothr_i (
    .clk(clk), .rst(rst), .en_i(en_i), .evt_cnt_i(evt_cnt_i),
    .cfg_wr_i(cfg_wr_i), .cfg_thr_i(cfg_thr_i), .cfg_mode_i(cfg_mode_i),
    .cfg_cnt1_i(cfg_cnt1_i), .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
    .ovf_clr_i(ovf_clr_i), .cnt_o(n_cnt_o), .ovf_o(n_ovf_o),
    .cap_thr_o(n_cap_thr_o), .thr_o(n_thr_o), .mode_o(n_mode_o), .cnt1_o(n_cnt1_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cfg(input logic [11:0] thr, input logic [1:0] mode, input logic c1);
    cfg_wr_i = 1'b1; cfg_thr_i = thr; cfg_mode_i = mode; cfg_cnt1_i = c1;
    tick();
    cfg_wr_i = 1'b0;
  endtask

  task automatic setcnt(input logic [63:0] v);
    cnt_wr_i = 1'b1; cnt_wdata_i = v;
    tick();
    cnt_wr_i = 1'b0;
  endtask

  task automatic run_evt(input logic [3:0] e);
    en_i = 1'b1; evt_cnt_i = e;
    tick();
    en_i = 1'b0; evt_cnt_i = '0;
  endtask

  function automatic bit ref_pass(input int e, input int t, input int m);
    case (m)
      0: return e != t;
      1: return e == t;
      2: return e >= t;
      default: return e < t;
    endcase
  endfunction

  task automatic t_reset();
    chk("R1", "cnt after reset", cnt_o, 64'd0);
    chk("R1", "ovf after reset", {63'd0, ovf_o}, 64'd0);
    chk("R1", "thr after reset", {52'd0, thr_o}, 64'd0);
    chk("R1", "mode/cnt1 after reset", {61'd0, mode_o, cnt1_o}, 64'd0);
    chk("R5", "capability", {52'd0, cap_thr_o}, 64'd255);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      longint exp = 0;
      cfg(12'd5, 2'(m), 1'b0);
      setcnt(64'd0);
      for (int e = 0; e < 16; e++) begin
        run_evt(4'(e));
        if (ref_pass(e, 5, m)) exp += e;
      end
      chk("R2", $sformatf("mode %0d sum (R3 raw add)", m), cnt_o, 64'(exp));
      chk("R2", "mode readback", {62'd0, mode_o}, 64'(m));
    end
    cfg(12'd2, 2'd2, 1'b0);
    setcnt(64'd0);
    run_evt(4'd1);
    chk("R3", "failing cycle leaves counter", cnt_o, 64'd0);
    run_evt(4'd3);
    chk("R3", "passing cycle adds count", cnt_o, 64'd3);
  endtask

  task automatic t_count1();
    cfg(12'd0, 2'd2, 1'b1);
    setcnt(64'd0);
    for (int e = 0; e < 16; e++) run_evt(4'(e));
    chk("R4", "one per passing cycle", cnt_o, 64'd16);
    cfg(12'd0, 2'd1, 1'b1);
    setcnt(64'd0);
    run_evt(4'd0); run_evt(4'd0); run_evt(4'd4);
    chk("R4", "zero-event cycle adds one", cnt_o, 64'd2);
  endtask

  task automatic t_clamp();
    cfg(12'd4095, 2'd2, 1'b0);
    chk("R5", "clamp 4095", {52'd0, thr_o}, 64'd255);
    setcnt(64'd0);
    run_evt(4'd15);
    chk("R5", "ge clamped 255 blocks 15", cnt_o, 64'd0);
    cfg(12'd300, 2'd3, 1'b0);
    chk("R5", "clamp 300", {52'd0, thr_o}, 64'd255);
    run_evt(4'd15);
    chk("R5", "lt clamped 255 passes 15", cnt_o, 64'd15);
    cfg(12'd255, 2'd3, 1'b0);
    chk("R5", "255 kept", {52'd0, thr_o}, 64'd255);
    cfg(12'd7, 2'd3, 1'b0);
    chk("R5", "7 kept", {52'd0, thr_o}, 64'd7);
  endtask

  task automatic t_enable();
    cfg(12'd0, 2'd2, 1'b0);
    setcnt(64'd100);
    en_i = 1'b0; evt_cnt_i = 4'd9;
    tick(); tick();
    evt_cnt_i = '0;
    chk("R7", "disabled holds", cnt_o, 64'd100);
    run_evt(4'd9);
    chk("R7", "enabled counts", cnt_o, 64'd109);
  endtask

  task automatic t_wr_prio();
    en_i = 1'b1; evt_cnt_i = 4'd6; cnt_wr_i = 1'b1; cnt_wdata_i = 64'h1234;
    tick();
    cnt_wr_i = 1'b0; en_i = 1'b0; evt_cnt_i = '0;
    chk("R8", "write beats increment", cnt_o, 64'h1234);
  endtask

  task automatic t_wrap();
    cfg(12'd0, 2'd2, 1'b0);
    setcnt(64'hFFFF_FFFF_FFFF_FFFD);
    run_evt(4'd5);
    chk("R9", "wrap value", cnt_o, 64'd2);
    chk("R9", "ovf set", {63'd0, ovf_o}, 64'd1);
    run_evt(4'd1);
    chk("R9", "ovf sticky", {63'd0, ovf_o}, 64'd1);
    ovf_clr_i = 1'b1; tick(); ovf_clr_i = 1'b0;
    chk("R9", "ovf cleared", {63'd0, ovf_o}, 64'd0);
    setcnt(64'hFFFF_FFFF_FFFF_FFFF);
    ovf_clr_i = 1'b1; run_evt(4'd1); ovf_clr_i = 1'b0;
    chk("R9", "set wins over clear", {63'd0, ovf_o}, 64'd1);
    chk("R9", "wrap to zero", cnt_o, 64'd0);
    ovf_clr_i = 1'b1; tick(); ovf_clr_i = 1'b0;
  endtask

  task automatic t_cfg_timing();
    cfg(12'd0, 2'd2, 1'b0);
    setcnt(64'd0);
    cfg_wr_i = 1'b1; cfg_thr_i = 12'd3; cfg_mode_i = 2'd1; cfg_cnt1_i = 1'b0;
    run_evt(4'd7);
    cfg_wr_i = 1'b0;
    chk("R10", "old config on write cycle", cnt_o, 64'd7);
    run_evt(4'd7);
    chk("R10", "new config rejects 7", cnt_o, 64'd7);
    run_evt(4'd3);
    chk("R10", "new config accepts 3", cnt_o, 64'd10);
  endtask

  task automatic t_nothr();
    cfg(12'd9, 2'd1, 1'b1);
    setcnt(64'd0);
    run_evt(4'd1); run_evt(4'd2); run_evt(4'd3);
    chk("R6", "absent: raw sum", n_cnt_o, 64'd6);
    chk("R6", "present: eq 9 rejects", cnt_o, 64'd0);
    chk("R6", "absent: capability", {52'd0, n_cap_thr_o}, 64'd0);
    chk("R6", "absent: thr/mode/cnt1", {49'd0, n_thr_o, n_mode_o, n_cnt1_o}, 64'd0);
  endtask

  initial begin
    rst = 1'b1; en_i = 1'b0; evt_cnt_i = '0; cfg_wr_i = 1'b0; cfg_thr_i = '0;
    cfg_mode_i = '0; cfg_cnt1_i = 1'b0; cnt_wr_i = 1'b0; cnt_wdata_i = '0;
    ovf_clr_i = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_modes();
    t_count1();
    t_clamp();
    t_enable();
    t_wr_prio();
    t_wrap();
    t_cfg_timing();
    t_nothr();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule